// File: doc/BRIEF.md
# Four-Core Local Interrupt Router

The block sits next to a cluster of four processor cores and decides which core is interrupted, and on which line, by each of the local sources. Each core has four timer lines and four mailbox-pending lines of its own. The cluster also has one GPU line that every core can see and one performance-monitor (PMU) line. For each source and core, a configuration register says whether it drives the core's normal interrupt (IRQ), its fast interrupt (FIQ), or neither. The GPU line is different: it is never broadcast. An encoded core number picks the single core that gets its IRQ, and a second core number picks the core that gets its FIQ.

Software reaches the block through a plain 32-bit register port with a byte address, a write strobe, write data and read data. A write is taken on the clock edge where the strobe is high. Read data is a combinational function of the address, so the port has no handshake and no back-pressure. The PMU enables can only be changed through one write-one-to-set address and one write-one-to-clear address, so two cores can each change their own bit without a read-modify-write race. For each core there is a read-only pending word. It shows which IRQ-enabled sources of that core are active, each at a fixed bit position. The core's IRQ pin is the OR of that word.

Top module: `core_irq_router`

## Requirements
- R1: After reset every configuration register is 0, every IRQ and FIQ output is low, and every defined offset reads 0.
- R2: Timer config for core n sits at offset 0x40+4n. Bits [3:0] are the IRQ enables of timers 0–3 and bits [7:4] their FIQ enables. It reads back what was written, with bits above 7 returning 0.
- R3: Mailbox config for core n sits at offset 0x50+4n. It uses the same layout as R2 and applies to mailbox lines 0–3.
- R4: Pending word for core n is read at offset 0x60+4n. Bit i (0–3) is timer i active AND its IRQ enable. Bit 4+i is mailbox i active AND its IRQ enable. Bit 8 is the GPU line routed to this core's IRQ. Bit 9 is the PMU line AND this core's PMU IRQ enable. Bits 10 and above read 0. Writes to the word have no effect.
- R5: A core's IRQ output is high exactly when its pending word is nonzero.
- R6: A core's FIQ output is high exactly when some active timer, mailbox, GPU or PMU source has its FIQ enable (or FIQ route) set for that core.
- R7: GPU routing at offset 0x0C holds the IRQ target core in bits [1:0] and the FIQ target core in bits [3:2]. An active GPU line raises IRQ on exactly one core and FIQ on exactly one core. After reset both targets are core 0.
- R8: Writing to offset 0x10 sets the PMU enable bits that are 1 in write data bits [7:0]. Bits [3:0] are the per-core IRQ enables and bits [7:4] the per-core FIQ enables. Other bits keep their value. Offset 0x10 reads the enable state.
- R9: Writing to offset 0x14 clears the PMU enable bits that are 1 in the write data and leaves the others unchanged. Offset 0x14 reads 0.
- R10: Control at offset 0x00 and prescaler at offset 0x08 are full 32-bit read/write registers that reset to 0. The prescaler holds 0x80000000 (the 19.2 MHz setting) once written.
- R11: Undefined and misaligned offsets read 0, and writes to them change no register.
- R12: A register write takes effect at the clock edge that accepts it, so the routing outputs follow it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| timer_irq_i | input | 16 | Timer lines; bit 4n+i is timer i of core n |
| mbox_pend_i | input | 16 | Mailbox-pending lines; bit 4n+i is mailbox i of core n |
| gpu_irq_i | input | 1 | Shared GPU interrupt line |
| pmu_irq_i | input | 1 | Performance-monitor interrupt line |
| core_irq_o | output | 4 | IRQ output per core |
| core_fiq_o | output | 4 | FIQ output per core |

## Verification
The assertions assume the source lines are level signals that the router only samples and never stores. They also assume a read happens in any cycle where the write strobe is low, so the pending-word check is valid whenever the address points at a pending offset. The bench changes source lines and addresses only on the falling clock edge and keeps the write strobe high for exactly one rising edge. This keeps the properties about PMU set, clear and hold aligned with single, well-defined writes. The GPU exclusivity property is only relied on in cycles where every other source is quiet, and the sweeps create such cycles whenever they step through the routing fields.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int ROUTE_W = 2;

  localparam logic [7:0] OFF_CTRL      = 8'h00;
  localparam logic [7:0] OFF_PRESC     = 8'h08;
  localparam logic [7:0] OFF_GPU_ROUTE = 8'h0C;
  localparam logic [7:0] OFF_PMU_SET   = 8'h10;
  localparam logic [7:0] OFF_PMU_CLR   = 8'h14;
  localparam logic [7:0] OFF_TCFG_BASE = 8'h40;
  localparam logic [7:0] OFF_MCFG_BASE = 8'h50;
  localparam logic [7:0] OFF_PEND_BASE = 8'h60;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PRESC,
    SEL_GPU,
    SEL_PMU_SET,
    SEL_PMU_CLR,
    SEL_TCFG,
    SEL_MCFG,
    SEL_PEND
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e             sel;
    logic [ROUTE_W-1:0]   core;
  } reg_dec_t;
endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
  import lirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCORES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_dec_t          dec
);
  logic [ADDR_W-1:0]  blk;
  logic [ROUTE_W-1:0] idx;
  logic               aligned;
  logic               idx_ok;

  always_comb begin
    blk     = {addr[ADDR_W-1:4], 4'h0};
    idx     = addr[3:2];
    aligned = (addr[1:0] == 2'b00);
    idx_ok  = (int'(idx) < NCORES);
    dec.sel  = SEL_NONE;
    dec.core = '0;
    if (aligned) begin
      if (addr == ADDR_W'(OFF_CTRL))           dec.sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFF_PRESC))     dec.sel = SEL_PRESC;
      else if (addr == ADDR_W'(OFF_GPU_ROUTE)) dec.sel = SEL_GPU;
      else if (addr == ADDR_W'(OFF_PMU_SET))   dec.sel = SEL_PMU_SET;
      else if (addr == ADDR_W'(OFF_PMU_CLR))   dec.sel = SEL_PMU_CLR;
      else if (idx_ok && blk == ADDR_W'(OFF_TCFG_BASE)) begin
        dec.sel  = SEL_TCFG;
        dec.core = idx;
      end else if (idx_ok && blk == ADDR_W'(OFF_MCFG_BASE)) begin
        dec.sel  = SEL_MCFG;
        dec.core = idx;
      end else if (idx_ok && blk == ADDR_W'(OFF_PEND_BASE)) begin
        dec.sel  = SEL_PEND;
        dec.core = idx;
      end
    end
  end
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCORES = 4,
  parameter int NTMR   = 4,
  parameter int NMBX   = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  reg_dec_t                             dec,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [DATA_W-1:0]                    ctrl_q,
  output logic [DATA_W-1:0]                    presc_q,
  output logic [2*ROUTE_W-1:0]                 gpu_route_q,
  output logic [2*NCORES-1:0]                  pmu_en_q,
  output logic [NCORES-1:0][2*NTMR-1:0]        tcfg_q,
  output logic [NCORES-1:0][2*NMBX-1:0]        mcfg_q
);
  localparam int PMU_W = 2 * NCORES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      presc_q     <= '0;
      gpu_route_q <= '0;
    end else if (we) begin
      if (dec.sel == SEL_CTRL)  ctrl_q      <= wdata;
      if (dec.sel == SEL_PRESC) presc_q     <= wdata;
      if (dec.sel == SEL_GPU)   gpu_route_q <= wdata[2*ROUTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmu_en_q <= '0;
    end else if (we && dec.sel == SEL_PMU_SET) begin
      pmu_en_q <= pmu_en_q | wdata[PMU_W-1:0];
    end else if (we && dec.sel == SEL_PMU_CLR) begin
      pmu_en_q <= pmu_en_q & ~wdata[PMU_W-1:0];
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_core_cfg
    logic hit_t, hit_m;
    assign hit_t = we && dec.sel == SEL_TCFG && dec.core == ROUTE_W'(c);
    assign hit_m = we && dec.sel == SEL_MCFG && dec.core == ROUTE_W'(c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tcfg_q[c] <= '0;
        mcfg_q[c] <= '0;
      end else begin
        if (hit_t) tcfg_q[c] <= wdata[2*NTMR-1:0];
        if (hit_m) mcfg_q[c] <= wdata[2*NMBX-1:0];
      end
    end
  end
endmodule

// File: rtl/lirq_core_route.sv
module lirq_core_route
  import lirq_pkg::*;
#(
  parameter int NTMR    = 4,
  parameter int NMBX    = 4,
  parameter int NCORES  = 4,
  parameter int CORE_ID = 0,
  localparam int PEND_W = NTMR + NMBX + 4
) (
  input  logic [NTMR-1:0]      tmr_i,
  input  logic [NMBX-1:0]      mbx_i,
  input  logic                 gpu_i,
  input  logic                 pmu_i,
  input  logic [2*NTMR-1:0]    tcfg_i,
  input  logic [2*NMBX-1:0]    mcfg_i,
  input  logic [2*ROUTE_W-1:0] gpu_route_i,
  input  logic [2*NCORES-1:0]  pmu_en_i,
  output logic [PEND_W-1:0]    pend_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  logic gpu_irq_here, gpu_fiq_here;
  logic tmr_fiq, mbx_fiq, pmu_fiq;

  assign gpu_irq_here = gpu_i && (gpu_route_i[ROUTE_W-1:0] == ROUTE_W'(CORE_ID));
  assign gpu_fiq_here = gpu_i && (gpu_route_i[2*ROUTE_W-1:ROUTE_W] == ROUTE_W'(CORE_ID));

  assign pend_o = {2'b00,
                   pmu_i & pmu_en_i[CORE_ID],
                   gpu_irq_here,
                   mbx_i & mcfg_i[NMBX-1:0],
                   tmr_i & tcfg_i[NTMR-1:0]};

  assign tmr_fiq = |(tmr_i & tcfg_i[2*NTMR-1:NTMR]);
  assign mbx_fiq = |(mbx_i & mcfg_i[2*NMBX-1:NMBX]);
  assign pmu_fiq = pmu_i & pmu_en_i[NCORES+CORE_ID];

  assign irq_o = |pend_o;
  assign fiq_o = tmr_fiq | mbx_fiq | gpu_fiq_here | pmu_fiq;
endmodule

// File: rtl/lirq_rdmux.sv
module lirq_rdmux
  import lirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCORES = 4,
  parameter int NTMR   = 4,
  parameter int NMBX   = 4,
  localparam int PEND_W = NTMR + NMBX + 4
) (
  input  reg_dec_t                          dec,
  input  logic [DATA_W-1:0]                 ctrl_i,
  input  logic [DATA_W-1:0]                 presc_i,
  input  logic [2*ROUTE_W-1:0]              gpu_route_i,
  input  logic [2*NCORES-1:0]               pmu_en_i,
  input  logic [NCORES-1:0][2*NTMR-1:0]     tcfg_i,
  input  logic [NCORES-1:0][2*NMBX-1:0]     mcfg_i,
  input  logic [NCORES-1:0][PEND_W-1:0]     pend_i,
  output logic [DATA_W-1:0]                 rdata
);
  always_comb begin
    rdata = '0;
    case (dec.sel)
      SEL_CTRL:    rdata = ctrl_i;
      SEL_PRESC:   rdata = presc_i;
      SEL_GPU:     rdata[2*ROUTE_W-1:0] = gpu_route_i;
      SEL_PMU_SET: rdata[2*NCORES-1:0] = pmu_en_i;
      SEL_TCFG:    rdata[2*NTMR-1:0] = tcfg_i[dec.core];
      SEL_MCFG:    rdata[2*NMBX-1:0] = mcfg_i[dec.core];
      SEL_PEND:    rdata[PEND_W-1:0] = pend_i[dec.core];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import lirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCORES = 4,
  parameter int NTMR   = 4,
  parameter int NMBX   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NCORES*NTMR-1:0]   timer_irq_i,
  input  logic [NCORES*NMBX-1:0]   mbox_pend_i,
  input  logic                     gpu_irq_i,
  input  logic                     pmu_irq_i,
  output logic [NCORES-1:0]        core_irq_o,
  output logic [NCORES-1:0]        core_fiq_o
);
  localparam int PEND_W = NTMR + NMBX + 4;

  reg_dec_t                        dec;
  logic [DATA_W-1:0]               ctrl_q, presc_q;
  logic [2*ROUTE_W-1:0]            gpu_route_q;
  logic [2*NCORES-1:0]             pmu_en_q;
  logic [NCORES-1:0][2*NTMR-1:0]   tcfg_q;
  logic [NCORES-1:0][2*NMBX-1:0]   mcfg_q;
  logic [NCORES-1:0][PEND_W-1:0]   pend_w;

  lirq_decode #(.ADDR_W(ADDR_W), .NCORES(NCORES)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  lirq_regs #(.DATA_W(DATA_W), .NCORES(NCORES), .NTMR(NTMR), .NMBX(NMBX)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (bus_we),
    .dec         (dec),
    .wdata       (bus_wdata),
    .ctrl_q      (ctrl_q),
    .presc_q     (presc_q),
    .gpu_route_q (gpu_route_q),
    .pmu_en_q    (pmu_en_q),
    .tcfg_q      (tcfg_q),
    .mcfg_q      (mcfg_q)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_route
    lirq_core_route #(
      .NTMR(NTMR), .NMBX(NMBX), .NCORES(NCORES), .CORE_ID(c)
    ) u_route (
      .tmr_i       (timer_irq_i[c*NTMR +: NTMR]),
      .mbx_i       (mbox_pend_i[c*NMBX +: NMBX]),
      .gpu_i       (gpu_irq_i),
      .pmu_i       (pmu_irq_i),
      .tcfg_i      (tcfg_q[c]),
      .mcfg_i      (mcfg_q[c]),
      .gpu_route_i (gpu_route_q),
      .pmu_en_i    (pmu_en_q),
      .pend_o      (pend_w[c]),
      .irq_o       (core_irq_o[c]),
      .fiq_o       (core_fiq_o[c])
    );
  end

  lirq_rdmux #(.DATA_W(DATA_W), .NCORES(NCORES), .NTMR(NTMR), .NMBX(NMBX)) u_rd (
    .dec         (dec),
    .ctrl_i      (ctrl_q),
    .presc_i     (presc_q),
    .gpu_route_i (gpu_route_q),
    .pmu_en_i    (pmu_en_q),
    .tcfg_i      (tcfg_q),
    .mcfg_i      (mcfg_q),
    .pend_i      (pend_w),
    .rdata       (bus_rdata)
  );
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCORES = 4,
  parameter int NTMR   = 4,
  parameter int NMBX   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_we,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic [NCORES*NTMR-1:0] timer_irq_i,
  input logic [NCORES*NMBX-1:0] mbox_pend_i,
  input logic                   gpu_irq_i,
  input logic                   pmu_irq_i,
  input logic [NCORES-1:0]      core_irq_o,
  input logic [NCORES-1:0]      core_fiq_o,
  input logic [2*NCORES-1:0]    pmu_en
);
  logic quiet, pmu_set_wr, pmu_clr_wr;
  assign quiet = (timer_irq_i == '0) && (mbox_pend_i == '0) && !pmu_irq_i;
  assign pmu_set_wr = bus_we && bus_addr == ADDR_W'(OFF_PMU_SET);
  assign pmu_clr_wr = bus_we && bus_addr == ADDR_W'(OFF_PMU_CLR);

  assert_no_source_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !gpu_irq_i) |-> (core_irq_o == '0 && core_fiq_o == '0));

  assert_gpu_single_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && gpu_irq_i) |-> ($countones(core_irq_o) == 1 && $countones(core_fiq_o) == 1));

  assert_pmu_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_set_wr |=> pmu_en == ($past(pmu_en) | $past(bus_wdata[2*NCORES-1:0])));

  assert_pmu_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_clr_wr |=> pmu_en == ($past(pmu_en) & ~$past(bus_wdata[2*NCORES-1:0])));

  assert_pmu_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pmu_set_wr || pmu_clr_wr) |=> $stable(pmu_en));

  assert_misaligned_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);

  for (genvar c = 0; c < NCORES; c++) begin : g_pend_chk
    assert_pend_matches_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && bus_addr == ADDR_W'(OFF_PEND_BASE + 8'(4 * c)))
        |-> (core_irq_o[c] == (bus_rdata != '0)));
  end
endmodule

bind core_irq_router lirq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCORES(NCORES), .NTMR(NTMR), .NMBX(NMBX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .timer_irq_i (timer_irq_i),
  .mbox_pend_i (mbox_pend_i),
  .gpu_irq_i   (gpu_irq_i),
  .pmu_irq_i   (pmu_irq_i),
  .core_irq_o  (core_irq_o),
  .core_fiq_o  (core_fiq_o),
  .pmu_en      (pmu_en_q)
);

// File: tb/sim_core_irq_router.sv
module sim_core_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] timer_irq_i = '0;
  logic [15:0] mbox_pend_i = '0;
  logic        gpu_irq_i = 1'b0;
  logic        pmu_irq_i = 1'b0;
  logic [3:0]  core_irq_o, core_fiq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  core_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq_i(timer_irq_i),
    .mbox_pend_i(mbox_pend_i), .gpu_irq_i(gpu_irq_i), .pmu_irq_i(pmu_irq_i),
    .core_irq_o(core_irq_o), .core_fiq_o(core_fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  undef_list [6];
    undef_list = '{8'h04, 8'h18, 8'h30, 8'h70, 8'h41, 8'hFC};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    settle();
    chk("R1 irq", {28'b0, core_irq_o}, 32'h0);
    chk("R1 fiq", {28'b0, core_fiq_o}, 32'h0);
    foreach (undef_list[i]) begin end
    begin
      logic [7:0] defs [7];
      defs = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h40, 8'h5C, 8'h64};
      foreach (defs[i]) begin
        rd(defs[i], d);
        chk("R1 reg", d, 32'h0);
      end
    end

    // R7: reset routing sends GPU to core 0 on both lines
    gpu_irq_i = 1'b1;
    settle();
    chk("R7 reset irq route", {28'b0, core_irq_o}, 32'h1);
    chk("R7 reset fiq route", {28'b0, core_fiq_o}, 32'h1);
    gpu_irq_i = 1'b0;

    // R10: control and prescaler
    wr(8'h00, 32'hDEADBEEF);
    rd(8'h00, d); chk("R10 ctrl", d, 32'hDEADBEEF);
    wr(8'h08, 32'h80000000);
    rd(8'h08, d); chk("R10 prescaler", d, 32'h80000000);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R10 ctrl clear", d, 32'h0);

    // R2 / R3: config read back, upper bits dropped
    for (int c = 0; c < 4; c++) begin
      wr(8'(8'h40 + 4 * c), 32'hFFFFFF00 | 32'(8'h11 * (c + 1)));
      wr(8'(8'h50 + 4 * c), 32'hABCDEF00 | 32'(8'h22 + c));
    end
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h40 + 4 * c), d); chk("R2 timer cfg", d, 32'(8'h11 * (c + 1)));
      rd(8'(8'h50 + 4 * c), d); chk("R3 mbox cfg", d, 32'(8'h22 + c));
      wr(8'(8'h40 + 4 * c), 32'h0);
      wr(8'(8'h50 + 4 * c), 32'h0);
    end

    // R12: write takes effect on the accepting edge
    timer_irq_i = 16'h0010;  // core 1 timer 0
    settle();
    chk("R12 before write", {28'b0, core_irq_o}, 32'h0);
    @(negedge clk);
    bus_addr = 8'h44; bus_wdata = 32'h01; bus_we = 1'b1;
    #2 chk("R12 same cycle", {28'b0, core_irq_o}, 32'h0);
    @(posedge clk);
    #1 bus_we = 1'b0;
    chk("R12 after edge", {28'b0, core_irq_o}, 32'h2);
    wr(8'h44, 32'h0);
    timer_irq_i = '0;

    // R4 / R5 / R6: timer sweep, every enable pattern against every input pattern
    for (int c = 0; c < 4; c++) begin
      for (int en = 0; en < 16; en++) begin
        logic [3:0] fen;
        fen = 4'(en) ^ 4'hA;
        wr(8'(8'h40 + 4 * c), {24'b0, fen, 4'(en)});
        for (int t = 0; t < 16; t++) begin
          logic [3:0] ep, fp;
          timer_irq_i = '0;
          timer_irq_i[c*4 +: 4] = 4'(t);
          ep = 4'(t) & 4'(en);
          fp = 4'(t) & fen;
          rd(8'(8'h60 + 4 * c), d);
          chk("R4 timer pending", d, {28'b0, ep});
          chk("R5 timer irq", {28'b0, core_irq_o}, (ep != 0) ? (32'h1 << c) : 32'h0);
          chk("R6 timer fiq", {28'b0, core_fiq_o}, (fp != 0) ? (32'h1 << c) : 32'h0);
        end
      end
      wr(8'(8'h40 + 4 * c), 32'h0);
    end
    timer_irq_i = '0;

    // R3 / R4 / R6: mailbox sweep
    for (int c = 0; c < 4; c++) begin
      for (int en = 0; en < 16; en += 3) begin
        logic [3:0] fen;
        fen = ~4'(en);
        wr(8'(8'h50 + 4 * c), {24'b0, fen, 4'(en)});
        for (int m = 0; m < 16; m++) begin
          logic [3:0] ep, fp;
          mbox_pend_i = '0;
          mbox_pend_i[c*4 +: 4] = 4'(m);
          ep = 4'(m) & 4'(en);
          fp = 4'(m) & fen;
          rd(8'(8'h60 + 4 * c), d);
          chk("R4 mbox pending", d, {24'b0, ep, 4'b0});
          chk("R6 mbox fiq", {28'b0, core_fiq_o}, (fp != 0) ? (32'h1 << c) : 32'h0);
        end
      end
      wr(8'(8'h50 + 4 * c), 32'h0);
    end
    mbox_pend_i = '0;

    // R7: every GPU routing combination
    gpu_irq_i = 1'b1;
    for (int is = 0; is < 4; is++) begin
      for (int fs = 0; fs < 4; fs++) begin
        wr(8'h0C, {28'hFFFFFFF, 2'(fs), 2'(is)} & 32'h0000000F);
        rd(8'h0C, d); chk("R7 route readback", d, 32'(fs * 4 + is));
        chk("R7 irq one core", {28'b0, core_irq_o}, 32'h1 << is);
        chk("R7 fiq one core", {28'b0, core_fiq_o}, 32'h1 << fs);
        for (int c = 0; c < 4; c++) begin
          rd(8'(8'h60 + 4 * c), d);
          chk("R4 gpu pending bit8", d, (c == is) ? 32'h100 : 32'h0);
        end
      end
    end
    gpu_irq_i = 1'b0;
    wr(8'h0C, 32'h0);

    // R8 / R9: PMU set and clear
    wr(8'h10, 32'h21);
    rd(8'h10, d); chk("R8 set", d, 32'h21);
    wr(8'h10, 32'h14);
    rd(8'h10, d); chk("R8 set keeps others", d, 32'h35);
    wr(8'h14, 32'h11);
    rd(8'h10, d); chk("R9 clear", d, 32'h24);
    rd(8'h14, d); chk("R9 clear reads zero", d, 32'h0);
    pmu_irq_i = 1'b1;
    settle();
    chk("R8 pmu irq core2", {28'b0, core_irq_o}, 32'h4);
    chk("R8 pmu fiq core1", {28'b0, core_fiq_o}, 32'h2);
    rd(8'h68, d); chk("R4 pmu pending bit9", d, 32'h200);
    rd(8'h60, d); chk("R4 pmu not on core0", d, 32'h0);

    // R11 and R4 read-only: stray writes leave every register alone
    wr(8'h08, 32'h80000000);
    wr(8'h44, 32'h5A);
    foreach (undef_list[i]) wr(undef_list[i], 32'hFFFFFFFF);
    wr(8'h68, 32'h0);
    foreach (undef_list[i]) begin
      rd(undef_list[i], d);
      chk("R11 undefined reads zero", d, 32'h0);
    end
    rd(8'h00, d); chk("R11 ctrl untouched", d, 32'h0);
    rd(8'h08, d); chk("R11 prescaler untouched", d, 32'h80000000);
    rd(8'h0C, d); chk("R11 route untouched", d, 32'h0);
    rd(8'h10, d); chk("R11 pmu untouched", d, 32'h24);
    rd(8'h44, d); chk("R11 tcfg untouched", d, 32'h5A);
    rd(8'h68, d); chk("R4 pending write ignored", d, 32'h200);
    pmu_irq_i = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule